// File: doc/BRIEF.md
# Logical Shift-Right Execute Unit

This block is the execute slice for the logical shift-right instruction of a small accumulator CPU that works on either 8-bit or 16-bit data. Each cycle that `valid_i` is high, it takes an opcode byte, a data-width flag, the low byte of the direct page register, the operand and the current status byte. It shifts the operand right by one bit and forms the new status byte. It also decodes the addressing mode and instruction length, and computes the total cycle count. That count includes the penalties for wide data and for a direct page base that is not aligned.

All results are registered and appear one clock after the strobe, together with a one-cycle `valid_o` pulse. They hold until the next strobe. Operand fetch, write-back and address generation belong to other parts of the pipeline. An opcode that is not one of the five shift-right forms is reported on `illegal_o` and leaves the status byte untouched.

Top module: `lsr_exec_unit`

## Requirements
- R1: In 16-bit mode (`wide_i`=1) the result is the operand shifted right by one bit, with bit 15 set to zero.
- R2: In 8-bit mode (`wide_i`=0) bits 7..0 of the result are operand bits 7..0 shifted right by one bit, with bit 7 set to zero. Bits 15..8 pass through unchanged. Z and C use only the low byte.
- R3: On a legal opcode, the status byte has N (bit 7) cleared. Z (bit 1) is set exactly when the shifted field is zero. C (bit 0) takes the bit shifted out, and the old carry is discarded.
- R4: Status bits 6..2 leave the block equal to their input values.
- R5: Decode: 0x4A gives mode 1 (accumulator) and length 1. 0x4E gives mode 2 (absolute) and length 3. 0x46 gives mode 3 (direct page) and length 2. 0x5E gives mode 4 (absolute indexed by X) and length 3. 0x56 gives mode 5 (direct page indexed by X) and length 2.
- R6: Base cycle counts are 2, 6, 5, 7 and 6 for modes 1 to 5, in that order.
- R7: Every mode except accumulator adds 2 cycles when `wide_i`=1.
- R8: Modes 3 and 5 add 1 cycle when `dp_low_i` is nonzero. The other modes ignore `dp_low_i`.
- R9: Any other opcode gives `illegal_o`=1, mode 0, length 0 and cycles 0. The status byte equals `flags_i` and the result equals the operand.
- R10: Outputs update on the clock edge that samples `valid_i`=1, and `valid_o` is high only in the cycle after the strobe. Without a strobe, all outputs hold.
- R11: Reset drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| opcode_i | input | 8 | Opcode byte |
| wide_i | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| dp_low_i | input | 8 | Low byte of the direct page register |
| operand_i | input | 16 | Operand value |
| flags_i | input | 8 | Status byte in (N=7, Z=1, C=0) |
| valid_o | output | 1 | Result strobe |
| result_o | output | 16 | Shifted value |
| flags_o | output | 8 | Status byte out |
| len_o | output | 2 | Instruction length in bytes |
| mode_o | output | 3 | Addressing mode code |
| cycles_o | output | 4 | Total cycle count |
| illegal_o | output | 1 | Opcode is not a shift-right form |

## Verification
The bench runs every legal opcode across both data widths, with `dp_low_i` both zero and nonzero. A wrong penalty rule shows up as a cycle count off by one or two, for example on an absolute mode that wrongly takes the direct page penalty or on accumulator mode that wrongly takes the width penalty. Operands 0x0001, 0x8000, 0x0000 and 0xFFFF are driven in 8-bit mode to catch a Z computed over the whole word, a lost upper byte, and a top bit or carry taken from the wrong lane. Illegal opcodes are checked to leave the status byte and the operand untouched. Idle cycles are checked to leave every output frozen.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int CYC_W = 4;
  localparam int LEN_W = 2;
  localparam int FLG_N = 7;
  localparam int FLG_Z = 1;
  localparam int FLG_C = 0;

  typedef enum logic [2:0] {
    MODE_NONE = 3'd0,
    MODE_ACC  = 3'd1,
    MODE_ABS  = 3'd2,
    MODE_DP   = 3'd3,
    MODE_ABSX = 3'd4,
    MODE_DPX  = 3'd5
  } mode_e;
endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_pkg::*;
(
  input  logic [7:0]       opcode_i,
  output mode_e            mode_o,
  output logic [LEN_W-1:0] len_o,
  output logic [CYC_W-1:0] base_o,
  output logic             legal_o,
  output logic             acc_o,
  output logic             dp_o
);
  always_comb begin
    mode_o  = MODE_NONE;
    len_o   = '0;
    base_o  = '0;
    unique case (opcode_i)
      8'h4A: begin mode_o = MODE_ACC;  len_o = 2'd1; base_o = 4'd2; end
      8'h4E: begin mode_o = MODE_ABS;  len_o = 2'd3; base_o = 4'd6; end
      8'h46: begin mode_o = MODE_DP;   len_o = 2'd2; base_o = 4'd5; end
      8'h5E: begin mode_o = MODE_ABSX; len_o = 2'd3; base_o = 4'd7; end
      8'h56: begin mode_o = MODE_DPX;  len_o = 2'd2; base_o = 4'd6; end
      default: ;
    endcase
  end

  assign legal_o = (mode_o != MODE_NONE);
  assign acc_o   = (mode_o == MODE_ACC);
  assign dp_o    = (mode_o == MODE_DP) || (mode_o == MODE_DPX);
endmodule

// File: rtl/lsr_shifter.sv
module lsr_shifter #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              carry_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] res_wide;
  logic [DATA_W-1:0] res_narrow;

  assign res_wide   = {1'b0, operand_i[DATA_W-1:1]};
  assign res_narrow = {operand_i[DATA_W-1:HALF_W], 1'b0, operand_i[HALF_W-1:1]};

  assign result_o = wide_i ? res_wide : res_narrow;
  assign carry_o  = operand_i[0];
  // narrow mode: zero test over the low lane only
  assign zero_o   = wide_i ? (res_wide == '0) : (res_narrow[HALF_W-1:0] == '0);
endmodule

// File: rtl/lsr_cycles.sv
module lsr_cycles
  import lsr_pkg::*;
#(
  parameter int DPL_W = 8
) (
  input  logic [CYC_W-1:0] base_i,
  input  logic             legal_i,
  input  logic             acc_i,
  input  logic             dp_i,
  input  logic             wide_i,
  input  logic [DPL_W-1:0] dp_low_i,
  output logic [CYC_W-1:0] cycles_o
);
  logic [CYC_W-1:0] wide_pen;
  logic [CYC_W-1:0] align_pen;

  assign wide_pen  = (wide_i && !acc_i) ? CYC_W'(2) : '0;
  assign align_pen = (dp_i && (dp_low_i != '0)) ? CYC_W'(1) : '0;
  assign cycles_o  = legal_i ? (base_i + wide_pen + align_pen) : '0;
endmodule

// File: rtl/lsr_exec_unit.sv
module lsr_exec_unit
  import lsr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DPL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic              wide_i,
  input  logic [DPL_W-1:0]  dp_low_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [7:0]        flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [7:0]        flags_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [2:0]        mode_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              illegal_o
);
  mode_e             dec_mode;
  logic [LEN_W-1:0]  dec_len;
  logic [CYC_W-1:0]  dec_base;
  logic              dec_legal, dec_acc, dec_dp;
  logic [DATA_W-1:0] sh_res;
  logic              sh_zero, sh_carry;
  logic [CYC_W-1:0]  cyc_total;
  logic [7:0]        flags_nxt;
  logic [DATA_W-1:0] res_nxt;

  lsr_decode u_decode (
    .opcode_i (opcode_i),
    .mode_o   (dec_mode),
    .len_o    (dec_len),
    .base_o   (dec_base),
    .legal_o  (dec_legal),
    .acc_o    (dec_acc),
    .dp_o     (dec_dp)
  );

  lsr_shifter #(.DATA_W(DATA_W)) u_shifter (
    .operand_i (operand_i),
    .wide_i    (wide_i),
    .result_o  (sh_res),
    .zero_o    (sh_zero),
    .carry_o   (sh_carry)
  );

  lsr_cycles #(.DPL_W(DPL_W)) u_cycles (
    .base_i   (dec_base),
    .legal_i  (dec_legal),
    .acc_i    (dec_acc),
    .dp_i     (dec_dp),
    .wide_i   (wide_i),
    .dp_low_i (dp_low_i),
    .cycles_o (cyc_total)
  );

  always_comb begin
    flags_nxt = flags_i;
    res_nxt   = operand_i;
    if (dec_legal) begin
      flags_nxt[FLG_N] = 1'b0;
      flags_nxt[FLG_Z] = sh_zero;
      flags_nxt[FLG_C] = sh_carry;
      res_nxt          = sh_res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      flags_o   <= '0;
      len_o     <= '0;
      mode_o    <= '0;
      cycles_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_nxt;
        flags_o   <= flags_nxt;
        len_o     <= dec_len;
        mode_o    <= dec_mode;
        cycles_o  <= cyc_total;
        illegal_o <= !dec_legal;
      end
    end
  end
endmodule

// File: rtl/lsr_exec_unit_chk.sv
module lsr_exec_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              wide_i,
  input logic [7:0]        flags_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [7:0]        flags_o,
  input logic [1:0]        len_o,
  input logic [3:0]        cycles_o,
  input logic              illegal_o
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o); // R10
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o); // R10
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> $stable(result_o) && $stable(flags_o) && $stable(cycles_o)); // R10
  AST_N_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_o && !illegal_o) |-> !flags_o[7]); // R3
  AST_FLAGS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> flags_o[6:2] == $past(flags_i[6:2])); // R4
  AST_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_i && wide_i) |=> (illegal_o || !result_o[DATA_W-1])); // R1
  AST_CYC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_o && !illegal_o) |-> (cycles_o >= 4'd2 && cycles_o <= 4'd9)); // R6
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (valid_o && illegal_o) |-> (cycles_o == 4'd0 && len_o == 2'd0)); // R9
endmodule

bind lsr_exec_unit lsr_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .wide_i    (wide_i),
  .flags_i   (flags_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .flags_o   (flags_o),
  .len_o     (len_o),
  .cycles_o  (cycles_o),
  .illegal_o (illegal_o)
);

// File: tb/lsr_exec_unit_bench.sv
module lsr_exec_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic        wide_i = 1'b0;
  logic [7:0]  dp_low_i = '0;
  logic [15:0] operand_i = '0;
  logic [7:0]  flags_i = '0;
  logic        valid_o;
  logic [15:0] result_o;
  logic [7:0]  flags_o;
  logic [1:0]  len_o;
  logic [2:0]  mode_o;
  logic [3:0]  cycles_o;
  logic        illegal_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  lsr_exec_unit u_lsr_exec_unit (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic w, input logic [7:0] dp,
                       input logic [15:0] opnd, input logic [7:0] fl);
    @(negedge clk_i);
    opcode_i = op; wide_i = w; dp_low_i = dp; operand_i = opnd; flags_i = fl;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // reference model built from the requirements
  task automatic expect_all(input logic [7:0] op, input logic w, input logic [7:0] dp,
                            input logic [15:0] opnd, input logic [7:0] fl);
    int md, ln, cy;
    logic [15:0] r;
    logic [7:0] f;
    logic z;
    md = 0; ln = 0; cy = 0;
    case (op)
      8'h4A: begin md = 1; ln = 1; cy = 2; end
      8'h4E: begin md = 2; ln = 3; cy = 6; end
      8'h46: begin md = 3; ln = 2; cy = 5; end
      8'h5E: begin md = 4; ln = 3; cy = 7; end
      8'h56: begin md = 5; ln = 2; cy = 6; end
      default: ;
    endcase
    if (md != 0) begin
      if (w && md != 1) cy += 2;
      if ((md == 3 || md == 5) && dp != 0) cy += 1;
      if (w) begin r = opnd >> 1; z = (r == 0); end
      else begin r = {opnd[15:8], 8'(opnd[7:0] >> 1)}; z = (r[7:0] == 0); end
      f = {1'b0, fl[6:2], z, opnd[0]};
    end else begin
      r = opnd; f = fl;
    end
    chk("R10", "valid_o", int'(valid_o), 1);
    chk(w ? "R1" : "R2", "result_o", int'(result_o), int'(r));
    chk("R3", "flags_o[7,1,0]", int'({flags_o[7], flags_o[1:0]}), int'({f[7], f[1:0]}));
    chk("R4", "flags_o[6:2]", int'(flags_o[6:2]), int'(f[6:2]));
    chk("R5", "mode_o", int'(mode_o), md);
    chk("R5", "len_o", int'(len_o), ln);
    chk(md == 0 ? "R9" : (dp != 0 ? "R8" : (w ? "R7" : "R6")), "cycles_o", int'(cycles_o), cy);
    chk("R9", "illegal_o", int'(illegal_o), md == 0 ? 1 : 0);
  endtask

  task automatic t_reset;
    chk("R11", "reset outputs", int'({valid_o, result_o, flags_o, len_o, mode_o, cycles_o, illegal_o}), 0);
  endtask

  task automatic t_sweep;
    logic [7:0] ops [5] = '{8'h4A, 8'h4E, 8'h46, 8'h5E, 8'h56};
    for (int i = 0; i < 5; i++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++) begin
          apply(ops[i], w[0], d ? 8'h31 : 8'h00, 16'hA5C3, 8'h7C);
          expect_all(ops[i], w[0], d ? 8'h31 : 8'h00, 16'hA5C3, 8'h7C);
        end
  endtask

  task automatic t_corners;
    logic [15:0] vals [4] = '{16'h0001, 16'h8000, 16'h0000, 16'hFFFF};
    for (int v = 0; v < 4; v++)
      for (int w = 0; w < 2; w++) begin
        apply(8'h4A, w[0], 8'h00, vals[v], 8'hA1);
        expect_all(8'h4A, w[0], 8'h00, vals[v], 8'hA1);
      end
  endtask

  task automatic t_illegal;
    logic [7:0] ops [4] = '{8'h00, 8'h4B, 8'h6A, 8'hFF};
    for (int i = 0; i < 4; i++) begin
      apply(ops[i], 1'b1, 8'h10, 16'h1235, 8'hC3);
      expect_all(ops[i], 1'b1, 8'h10, 16'h1235, 8'hC3);
    end
  endtask

  task automatic t_hold;
    apply(8'h56, 1'b1, 8'h01, 16'h0100, 8'h00);
    expect_all(8'h56, 1'b1, 8'h01, 16'h0100, 8'h00);
    @(negedge clk_i);
    opcode_i = 8'h4A; operand_i = 16'hFFFF; flags_i = 8'hFF; wide_i = 1'b0;
    chk("R10", "valid_o idle", int'(valid_o), 0);
    @(negedge clk_i);
    chk("R10", "result held", int'(result_o), 16'h0080);
    chk("R10", "cycles held", int'(cycles_o), 9);
    chk("R10", "flags held", int'(flags_o), 8'h00);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_sweep();
    t_corners();
    t_illegal();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule